// File: doc/BRIEF.md
# Chunked Thermometer-Code Vector Comparator

This block holds a small vector of unsigned elements and compares every one of them, in parallel, against a single broadcast scalar. It reports one greater-than, one equal and one less-than bit per lane. Each element is not stored in binary. The element is cut into equal chunks, and each chunk is kept as a thermometer code: a run of ones whose length equals the chunk value. Comparing a chunk against the matching chunk of the scalar then needs no adder. The block reads the one code bit that the scalar chunk selects, plus the bit just below it.

Software or a neighbouring engine first loads elements through an indexed write port. The write port does the binary-to-thermometer conversion in the same cycle that it stores the element. A comparison starts with a valid/ready handshake that carries the scalar. A controller then steps through the chunks from least to most significant, one chunk per clock. Each step folds that chunk's outcome into running greater-than and equal flags for every lane. When the last chunk has been folded in, the three result vectors are loaded and a one-cycle done pulse is raised. The number of steps follows the chunk count, not the element width. Raising the chunk count shrinks the code storage and adds merge steps.

Top module: `vecCompareTop`

## Requirements
- R1: A write with `wrEn` high while `startReady` is high stores `wrData` into lane `wrIdx` only. The stored value is what the next comparison of that lane uses.
- R2: After a comparison, `gtVec[i]` is 1 exactly when element i is greater than the scalar, both read as unsigned ELEM_W-bit numbers. This includes scalar 0 and scalar 2^ELEM_W−1.
- R3: After a comparison, `eqVec[i]` is 1 exactly when element i equals the scalar.
- R4: After a comparison, `ltVec[i]` is 1 exactly when element i is less than the scalar. At each completion exactly one of the three bits is set in every lane.
- R5: The comparison is accepted at a clock edge where `startValid` and `startReady` are both high. `done` is then high for exactly one cycle, directly after the CHUNKS-th following clock edge (2 edges by default).
- R6: `startReady` is low from the accepting edge until `done` is raised, and it is high while `done` is high. A `startValid` pulse while `startReady` is low is ignored, and the scalar in use is not changed.
- R7: A write presented while `startReady` is low is ignored, and the element keeps its previous value.
- R8: The result vectors change only in the cycle where `done` is high. Otherwise they hold their value, including during a later comparison, until that comparison completes.
- R9: After reset, all three result vectors and `done` are 0, `startReady` is 1, and every stored element reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Element write strobe |
| wrIdx | input | $clog2(LANES) | Lane index of the write |
| wrData | input | ELEM_W | Unsigned binary element value |
| startValid | input | 1 | Request to compare against `startScalar` |
| startScalar | input | ELEM_W | Unsigned scalar broadcast to all lanes |
| startReady | output | 1 | High when a start or a write can be accepted |
| done | output | 1 | One-cycle pulse when new results are loaded |
| gtVec | output | LANES | Per-lane element greater than scalar |
| eqVec | output | LANES | Per-lane element equal to scalar |
| ltVec | output | LANES | Per-lane element less than scalar |

## Verification
The checker watches the handshake and timing on every cycle. It checks that `done` lasts one cycle and comes exactly CHUNKS edges after acceptance, that `startReady` drops on acceptance and is back by completion, that the results move only together with `done`, and that each lane carries exactly one of greater, equal or less at completion. Whether the chosen bit is the correct one can only be shown by the bench's reference model, which holds the element values as plain integers. The same holds for ignored writes and ignored starts while busy, for the zeroed storage after reset, and for chunk-boundary values such as 0x0F against 0x10, since only the scenarios exercise them.

// File: rtl/vecCmpPkg.sv
package vecCmpPkg;

  // Strobes from the sequencer to the lane datapath.
  typedef struct packed {
    logic wrAllow;   // element writes may be taken this cycle
    logic capture;   // latch scalar and clear the running flags
    logic merge;     // fold the selected chunk into the running flags
    logic commit;    // load result registers (coincides with last merge)
  } cmpStrobes_t;

endpackage

// File: rtl/thermEncoder.sv
module thermEncoder #(
  parameter int CHUNK_W = 4,
  localparam int CODE_W = (1 << CHUNK_W) - 1
) (
  input  logic [CHUNK_W-1:0] value,
  output logic [CODE_W-1:0]  code
);
  // code[i] is 1 for every position below the value
  always_comb begin
    for (int i = 0; i < CODE_W; i++) begin
      code[i] = (i < int'(value));
    end
  end
endmodule

// File: rtl/laneCell.sv
module laneCell
  import vecCmpPkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int CHUNKS = 2,
  localparam int CHUNK_W = ELEM_W / CHUNKS,
  localparam int CODE_W = (1 << CHUNK_W) - 1,
  localparam int CNT_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              laneWr,
  input  logic [ELEM_W-1:0] wrData,
  input  logic [ELEM_W-1:0] scalarQ,
  input  logic [CNT_W-1:0]  chunkSel,
  input  cmpStrobes_t       strobes,
  output logic              gtRes,
  output logic              eqRes,
  output logic              ltRes
);
  logic [CODE_W-1:0] codeStore [CHUNKS];
  logic [CODE_W-1:0] codeIn    [CHUNKS];

  // One encoder per chunk of the incoming binary element
  for (genvar c = 0; c < CHUNKS; c++) begin : g_enc
    thermEncoder #(.CHUNK_W(CHUNK_W)) u_enc (
      .value(wrData[c*CHUNK_W +: CHUNK_W]),
      .code (codeIn[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codeStore[c] <= '0;
      end else if (laneWr) begin
        codeStore[c] <= codeIn[c];
      end
    end
  end

  // Chunk lookup: a single bit picked by the scalar chunk
  logic [CODE_W:0]    codeExt;
  logic [CHUNK_W-1:0] sChunk;
  logic [CHUNK_W-1:0] sBelow;
  logic               gtChunk;
  logic               eqChunk;
  logic               atOrAbove;

  always_comb begin
    codeExt   = {1'b0, codeStore[chunkSel]};
    sChunk    = scalarQ[chunkSel*CHUNK_W +: CHUNK_W];
    sBelow    = sChunk - 1'b1;
    gtChunk   = codeExt[sChunk];
    atOrAbove = (sChunk == '0) ? 1'b1 : codeExt[sBelow];
    eqChunk   = atOrAbove & ~gtChunk;
  end

  // Running merge from the least significant chunk upward
  logic gtAcc, eqAcc;
  logic gtNext, eqNext;

  always_comb begin
    gtNext = gtChunk | (eqChunk & gtAcc);
    eqNext = eqChunk & eqAcc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gtAcc <= 1'b0;
      eqAcc <= 1'b1;
    end else if (strobes.capture) begin
      gtAcc <= 1'b0;
      eqAcc <= 1'b1;
    end else if (strobes.merge) begin
      gtAcc <= gtNext;
      eqAcc <= eqNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gtRes <= 1'b0;
      eqRes <= 1'b0;
      ltRes <= 1'b0;
    end else if (strobes.commit) begin
      gtRes <= gtNext;
      eqRes <= eqNext;
      ltRes <= ~gtNext & ~eqNext;
    end
  end
endmodule

// File: rtl/cmpDatapath.sv
module cmpDatapath
  import vecCmpPkg::*;
#(
  parameter int LANES = 16,
  parameter int ELEM_W = 8,
  parameter int CHUNKS = 2,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ELEM_W-1:0] wrData,
  input  logic [ELEM_W-1:0] startScalar,
  input  logic [CNT_W-1:0]  chunkSel,
  input  cmpStrobes_t       strobes,
  output logic [LANES-1:0]  gtVec,
  output logic [LANES-1:0]  eqVec,
  output logic [LANES-1:0]  ltVec
);
  logic [ELEM_W-1:0] scalarQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scalarQ <= '0;
    end else if (strobes.capture) begin
      scalarQ <= startScalar;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic laneWr;
    assign laneWr = wrEn & strobes.wrAllow & (wrIdx == IDX_W'(i));

    laneCell #(.ELEM_W(ELEM_W), .CHUNKS(CHUNKS)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .laneWr  (laneWr),
      .wrData  (wrData),
      .scalarQ (scalarQ),
      .chunkSel(chunkSel),
      .strobes (strobes),
      .gtRes   (gtVec[i]),
      .eqRes   (eqVec[i]),
      .ltRes   (ltVec[i])
    );
  end
endmodule

// File: rtl/cmpControl.sv
module cmpControl
  import vecCmpPkg::*;
#(
  parameter int CHUNKS = 2,
  localparam int CNT_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHUNKS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startValid,
  output logic             startReady,
  output logic             done,
  output logic [CNT_W-1:0] chunkSel,
  output cmpStrobes_t      strobes
);
  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t        state;
  logic [CNT_W-1:0] chunkCnt;
  logic             lastStep;

  assign lastStep   = (state == ST_RUN) && (chunkCnt == LAST);
  assign startReady = (state == ST_IDLE);
  assign chunkSel   = chunkCnt;

  always_comb begin
    strobes         = '0;
    strobes.wrAllow = (state == ST_IDLE);
    strobes.capture = (state == ST_IDLE) && startValid;
    strobes.merge   = (state == ST_RUN);
    strobes.commit  = lastStep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      chunkCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= lastStep;
      case (state)
        ST_IDLE: begin
          if (startValid) begin
            state    <= ST_RUN;
            chunkCnt <= '0;
          end
        end
        ST_RUN: begin
          if (lastStep) begin
            state    <= ST_IDLE;
            chunkCnt <= '0;
          end else begin
            chunkCnt <= chunkCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vecCompareTop.sv
module vecCompareTop
  import vecCmpPkg::*;
#(
  parameter int LANES = 16,
  parameter int ELEM_W = 8,
  parameter int CHUNKS = 2,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ELEM_W-1:0] wrData,
  input  logic              startValid,
  input  logic [ELEM_W-1:0] startScalar,
  output logic              startReady,
  output logic              done,
  output logic [LANES-1:0]  gtVec,
  output logic [LANES-1:0]  eqVec,
  output logic [LANES-1:0]  ltVec
);
  initial begin
    if (ELEM_W % CHUNKS != 0) $error("element width must divide by chunk count");
  end

  cmpStrobes_t      strobes;
  logic [CNT_W-1:0] chunkSel;

  cmpControl #(.CHUNKS(CHUNKS)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startValid(startValid),
    .startReady(startReady),
    .done      (done),
    .chunkSel  (chunkSel),
    .strobes   (strobes)
  );

  cmpDatapath #(.LANES(LANES), .ELEM_W(ELEM_W), .CHUNKS(CHUNKS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .startScalar(startScalar),
    .chunkSel   (chunkSel),
    .strobes    (strobes),
    .gtVec      (gtVec),
    .eqVec      (eqVec),
    .ltVec      (ltVec)
  );
endmodule

// File: rtl/vecCompareChk.sv
module vecCompareChk #(
  parameter int LANES = 16,
  parameter int CHUNKS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startValid,
  input logic             startReady,
  input logic             done,
  input logic [LANES-1:0] gtVec,
  input logic [LANES-1:0] eqVec,
  input logic [LANES-1:0] ltVec
);
  // Edges counted since the accepting edge
  logic [7:0] runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runLen <= '0;
    end else if (startValid && startReady) begin
      runLen <= '0;
    end else if (!startReady && runLen != 8'hFF) begin
      runLen <= runLen + 1'b1;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (runLen == 8'(CHUNKS)));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startValid && startReady) |=> !startReady);

  // R6
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> startReady);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(gtVec) && $stable(eqVec) && $stable(ltVec)));

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((gtVec | eqVec | ltVec) == '1) && ((gtVec & eqVec) == '0)
              && ((gtVec & ltVec) == '0) && ((eqVec & ltVec) == '0)));
endmodule

bind vecCompareTop vecCompareChk #(.LANES(LANES), .CHUNKS(CHUNKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startValid(startValid),
  .startReady(startReady),
  .done      (done),
  .gtVec     (gtVec),
  .eqVec     (eqVec),
  .ltVec     (ltVec)
);

// File: tb/tb_vecCompareTop.sv
`timescale 1ns/1ps
module tb_vecCompareTop;
  localparam int LANES = 16;
  localparam int ELEM_W = 8;
  localparam int CHUNKS = 2;
  localparam int IDX_W = $clog2(LANES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wrEn = 1'b0;
  logic [IDX_W-1:0]  wrIdx = '0;
  logic [ELEM_W-1:0] wrData = '0;
  logic              startValid = 1'b0;
  logic [ELEM_W-1:0] startScalar = '0;
  logic              startReady, done;
  logic [LANES-1:0]  gtVec, eqVec, ltVec;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vecCompareTop #(.LANES(LANES), .ELEM_W(ELEM_W), .CHUNKS(CHUNKS)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .startValid(startValid), .startScalar(startScalar), .startReady(startReady),
    .done(done), .gtVec(gtVec), .eqVec(eqVec), .ltVec(ltVec)
  );

  // ---------------- behavioural reference model ----------------
  int        memM [LANES];
  int        scalarM = 0;
  bit        busyM = 0;
  int        stepsM = 0;
  bit        doneM = 0;
  bit [LANES-1:0] gtM = '0, eqM = '0, ltM = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (memM[i]) memM[i] = 0;
      busyM = 0; stepsM = 0; doneM = 0; scalarM = 0;
      gtM = '0; eqM = '0; ltM = '0;
    end else begin
      doneM = 0;
      if (busyM) begin
        stepsM++;
        if (stepsM == CHUNKS) begin
          for (int i = 0; i < LANES; i++) begin
            gtM[i] = memM[i] > scalarM;
            eqM[i] = memM[i] == scalarM;
            ltM[i] = memM[i] < scalarM;
          end
          doneM = 1;
          busyM = 0;
        end
      end else begin
        if (wrEn) memM[int'(wrIdx)] = int'(wrData);
        if (startValid) begin
          scalarM = int'(startScalar);
          busyM = 1;
          stepsM = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check(done == doneM, "R5 done timing", int'(done), int'(doneM));
      check(startReady == !busyM, "R6 startReady", int'(startReady), int'(!busyM));
      check(gtVec == gtM, "R2/R8 gtVec", int'(gtVec), int'(gtM));
      check(eqVec == eqM, "R3/R8 eqVec", int'(eqVec), int'(eqM));
      check(ltVec == ltM, "R4/R8 ltVec", int'(ltVec), int'(ltM));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic writeElem(input int idx, input int val);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrData = ELEM_W'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runCompare(input int s);
    startValid = 1'b1; startScalar = ELEM_W'(s);
    @(negedge clk);
    startValid = 1'b0;
    waitDone();
    @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    finishRun();
  end

  int lcg = 32'h1234;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(done == 1'b0, "R9 done after reset", int'(done), 0);
    check(startReady == 1'b1, "R9 startReady after reset", int'(startReady), 1);
    check(gtVec == '0 && eqVec == '0 && ltVec == '0, "R9 results after reset",
          int'(gtVec | eqVec | ltVec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 storage zero: scalar 0 gives all equal
    runCompare(0);
    check(eqVec == '1, "R9 stored elements zero", int'(eqVec), 16'hFFFF);

    // R1 load boundary values around the chunk edges
    writeElem(0, 8'h00); writeElem(1, 8'hFF); writeElem(2, 8'h0F);
    writeElem(3, 8'h10); writeElem(4, 8'hF0); writeElem(5, 8'h80);
    writeElem(6, 8'h7F); writeElem(7, 8'h11); writeElem(8, 8'h1F);
    writeElem(9, 8'h01); writeElem(10, 8'hFE); writeElem(11, 8'hEF);
    writeElem(12, 8'h0E); writeElem(13, 8'h20); writeElem(14, 8'h88);
    writeElem(15, 8'h10);

    // R2 R3 R4 several scalars, including extremes
    runCompare(8'h10);
    check(eqVec == 16'h8008, "R3 eq lanes for 0x10", int'(eqVec), 16'h8008);
    check(gtVec[2] == 1'b0 && ltVec[2] == 1'b1, "R4 0x0F below 0x10", int'(ltVec[2]), 1);
    runCompare(8'h0F);
    check(gtVec[3] == 1'b1, "R2 0x10 above 0x0F", int'(gtVec[3]), 1);
    runCompare(8'hFF);
    check(gtVec == '0, "R2 nothing above 0xFF", int'(gtVec), 0);
    runCompare(8'h00);
    check(ltVec == '0, "R4 nothing below 0", int'(ltVec), 0);
    runCompare(8'h80);
    runCompare(8'h1F);

    // R6 start while busy is ignored; R7 write while busy is ignored
    startValid = 1'b1; startScalar = 8'h88;
    @(negedge clk);
    startScalar = 8'h01; wrEn = 1'b1; wrIdx = 4'd14; wrData = 8'h01;
    @(negedge clk);
    startValid = 1'b0; wrEn = 1'b0;
    waitDone();
    @(negedge clk);
    check(eqVec[14] == 1'b1, "R6 scalar unchanged by busy start", int'(eqVec[14]), 1);
    runCompare(8'h01);
    check(eqVec[14] == 1'b0 && eqVec[9] == 1'b1, "R7 busy write ignored",
          int'(eqVec[14]), 0);

    // R1 write a single lane and see only it change
    writeElem(14, 8'h55);
    runCompare(8'h55);
    check(eqVec == 16'h4000, "R1 single lane write", int'(eqVec), 16'h4000);

    // R8 results hold across idle cycles
    repeat (5) @(negedge clk);
    check(eqVec == 16'h4000, "R8 results held", int'(eqVec), 16'h4000);

    // pseudo-random contents and scalars, back-to-back starts
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < LANES; i++) begin
        lcg = lcg * 1103515245 + 12345;
        writeElem(i, (lcg >> 8) & 8'hFF);
      end
      for (int k = 0; k < 6; k++) begin
        lcg = lcg * 1103515245 + 12345;
        startValid = 1'b1; startScalar = ELEM_W'((lcg >> 8) & 8'hFF);
        @(negedge clk);
        while (!startReady) @(negedge clk);
      end
      startValid = 1'b0;
      waitDone();
      @(negedge clk);
    end

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule